// File: doc/BRIEF.md
# Bit-Serial Memory Program Sequencer

This block sits on the host side of a small nonvolatile memory whose whole interface is a chip enable, an output enable, a write enable and one bidirectional data line. A client hands it a start address, a byte count of 1 to 32, a flat vector of data bytes and a one-cycle go pulse. The block turns that request into a train of single-bit bus cycles:
- a read that clears any half-finished sequence in the memory,
- the 16 address bits,
- every data bit,
- a read / write-1 / read trigger that starts programming.

Each bus cycle holds its strobe low for a fixed number of clocks. Chip enable then returns high, so the bus is free for other traffic between cycles.

Once programming has been triggered, the block polls the memory with read cycles spaced by a parameterised pause. A low data line means the memory is still busy; a high line means programming is finished. The result comes back as a one-cycle done pulse together with two status flags: a timeout when the poll budget runs out, and a reject when the request would wrap inside a 32-byte page. A rejected request produces no bus activity at all.

Top module: `bitser_prog_seq`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_io_oe` is 0, and `busy` and `done` are 0.
- R2: An accepted request first produces one read cycle. It then produces 16 write cycles that carry `req_addr` most significant bit first (bit 15 first), with no read cycle in between.
- R3: The address cycles are followed by 8×`req_len` write cycles. Byte k is taken from `req_data[8k+7:8k]`, byte 0 is sent first, and each byte is sent bit 7 first.
- R4: After the last data bit the block issues exactly one read cycle, one write cycle carrying 1, and one read cycle, in that order.
- R5: Bus cycles follow three rules. Every strobe-low interval lies inside a chip-enable-low interval. `mem_oe_n` and `mem_we_n` are never low together. Chip enable stays high for at least one clock between any two bus cycles.
- R6: `mem_io_oe` is 1 only while a write strobe is low, so the data line is released during read cycles and between cycles.
- R7: After the trigger, the block repeats poll read cycles until one samples `mem_io_in` = 1. It then pulses `done` with `st_timeout` = 0 and `st_reject` = 0, having issued N+1 polls when the first N polls read 0.
- R8: If MAX_POLLS consecutive poll reads all sample 0, the block stops polling after the last of them and pulses `done` with `st_timeout` = 1.
- R9: A request is rejected when `req_len` is 0, when `req_len` exceeds 32, or when `req_addr[4:0]` + `req_len` exceeds 32. A rejected request produces a `done` pulse with `st_reject` = 1 and no bus cycle.
- R10: A `req_go` pulse that arrives while `busy` is 1 is ignored. The running transfer's bus sequence is unchanged and no second `done` follows.
- R11: In every bus cycle the active strobe and chip enable stay low for exactly PULSE_W clocks.
- R12: `done` is high for a single clock, and `busy` is already 0 in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_go | input | 1 | Start pulse for a transfer request |
| req_addr | input | ADDR_W | Start address in the memory |
| req_len | input | LEN_W | Number of bytes to program (1 to PAGE_BYTES) |
| req_data | input | PAGE_BYTES*8 | Data bytes, byte 0 in the low bits |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock pulse at the end of a request |
| st_reject | output | 1 | Last request was refused (valid with done) |
| st_timeout | output | 1 | Last transfer ran out of poll reads (valid with done) |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable (read strobe), active low |
| mem_we_n | output | 1 | Memory write enable (write strobe), active low |
| mem_io_out | output | 1 | Value driven onto the data line |
| mem_io_oe | output | 1 | Drive enable for the data line |
| mem_io_in | input | 1 | Value seen on the data line |

## Verification
The hardest situations to reach are the ends of the polling loop. One is a memory that stays busy for exactly the last permitted poll. The other is a memory that stays busy one poll too long. Both depend on how the data line answers reads that only come after several hundred earlier bus cycles. The bench therefore models the memory itself: it counts completed bus cycles, and once that count passes the end of the trigger it answers a chosen number of poll reads with 0 before returning 1. That number is swept around the poll limit, and the byte count is swept across every value, both at the start of a page and flush against its end. A second go pulse is injected in the middle of a transfer to show that it leaves the bus stream untouched.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   // State of the single-bit bus cycle engine
   typedef enum logic [1:0] {
      BUS_IDLE,
      BUS_ACT,
      BUS_GAP
   } bus_st_t;

   // Step of the program sequence being issued
   typedef enum logic [2:0] {
      PH_RST,
      PH_ADDR,
      PH_DATA,
      PH_TRIG_R0,
      PH_TRIG_W1,
      PH_TRIG_R1,
      PH_POLL
   } phase_t;

   // Handshake state of the sequencer with the engine
   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ISSUE,
      SQ_WAIT,
      SQ_PAUSE
   } seq_st_t;

   // One bus cycle request
   typedef struct packed {
      logic is_wr;
      logic bit_v;
   } bus_cmd_t;

endpackage

// File: rtl/sbs_req_check.sv
module sbs_req_check #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_BYTES = 32,
   localparam int PB_W      = $clog2(PAGE_BYTES),
   localparam int LEN_W     = PB_W + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   output logic              ok
);
   localparam int SUM_W = LEN_W + 1;

   logic [SUM_W-1:0] end_pos;

   always_comb begin
      end_pos = SUM_W'(addr[PB_W-1:0]) + SUM_W'(len);
      ok = (len != '0) &&
           (SUM_W'(len) <= SUM_W'(PAGE_BYTES)) &&
           (end_pos <= SUM_W'(PAGE_BYTES));
   end

endmodule

// File: rtl/sbs_bus_cycle.sv
module sbs_bus_cycle #(
   parameter int PULSE_W = 3,
   parameter int GAP_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  sbs_pkg::bus_cmd_t cmd,
   output logic             ready,
   output logic             fin,
   output logic             rbit,
   output logic             ce_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             io_out,
   output logic             io_oe,
   input  logic             io_in
);
   import sbs_pkg::*;

   localparam int GW_CW = (GAP_W > 1) ? $clog2(GAP_W) : 1;

   bus_st_t           st;
   logic              wr_q;
   logic              bit_q;
   logic [GW_CW-1:0]  gcnt;
   logic              act_last;
   logic              gap_last;

   // Variant: no pulse counter when the strobe lasts a single clock
   generate
      if (PULSE_W == 1) begin : g_pw1
         assign act_last = 1'b1;
      end else begin : g_pwn
         localparam int PW_CW = $clog2(PULSE_W);
         logic [PW_CW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              pcnt <= '0;
            else if (st != BUS_ACT)  pcnt <= '0;
            else                     pcnt <= pcnt + 1'b1;
         end
         assign act_last = (pcnt == PW_CW'(PULSE_W - 1));
      end
   endgenerate

   assign gap_last = (gcnt == GW_CW'(GAP_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= BUS_IDLE;
         wr_q  <= 1'b0;
         bit_q <= 1'b0;
         gcnt  <= '0;
         rbit  <= 1'b0;
      end else begin
         unique case (st)
            BUS_IDLE: if (start) begin
               st    <= BUS_ACT;
               wr_q  <= cmd.is_wr;
               bit_q <= cmd.bit_v;
            end
            BUS_ACT: if (act_last) begin
               if (!wr_q) rbit <= io_in;
               st   <= BUS_GAP;
               gcnt <= '0;
            end
            BUS_GAP: begin
               if (gap_last) st <= BUS_IDLE;
               else          gcnt <= gcnt + 1'b1;
            end
            default: st <= BUS_IDLE;
         endcase
      end
   end

   assign ready  = (st == BUS_IDLE);
   assign fin    = (st == BUS_GAP) && gap_last;
   assign ce_n   = (st != BUS_ACT);
   assign we_n   = !((st == BUS_ACT) && wr_q);
   assign oe_n   = !((st == BUS_ACT) && !wr_q);
   assign io_oe  = (st == BUS_ACT) && wr_q;
   assign io_out = io_oe & bit_q;

   // Strobe-width checker counter
   logic [15:0] chk_low;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    chk_low <= '0;
      else if (!ce_n) chk_low <= chk_low + 1'b1;
      else           chk_low <= '0;
   end

   AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n || !we_n) |-> !ce_n);                                  // R5
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));                                           // R5
   AST_CE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce_n) |=> ce_n);                                        // R5
   AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe |-> !we_n);                                             // R6
   AST_FLOAT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !io_oe);                                            // R6
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce_n) |-> (chk_low == 16'(PULSE_W)));                   // R11

endmodule

// File: rtl/sbs_poll_watch.sv
module sbs_poll_watch #(
   parameter int POLL_GAP  = 200,
   parameter int MAX_POLLS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic poll_low,
   output logic last_poll,
   output logic pause_over
);
   localparam int CNT_W = $clog2(MAX_POLLS + 1);
   localparam int WC_W  = $clog2(POLL_GAP + 1);

   logic [CNT_W-1:0] polls;
   logic [WC_W-1:0]  wcnt;
   logic             run;

   assign last_poll  = (polls == CNT_W'(MAX_POLLS - 1));
   assign pause_over = run && (wcnt == WC_W'(POLL_GAP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         polls <= '0;
         wcnt  <= '0;
         run   <= 1'b0;
      end else begin
         if (clear)         polls <= '0;
         else if (poll_low) polls <= polls + 1'b1;

         if (poll_low) begin
            run  <= 1'b1;
            wcnt <= '0;
         end else if (run) begin
            if (pause_over) run <= 1'b0;
            else            wcnt <= wcnt + 1'b1;
         end
      end
   end

   AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      polls < CNT_W'(MAX_POLLS));                                   // R8

endmodule

// File: rtl/bitser_prog_seq.sv
module bitser_prog_seq #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_BYTES = 32,
   parameter int PULSE_W    = 3,
   parameter int GAP_W      = 2,
   parameter int POLL_GAP   = 200,
   parameter int MAX_POLLS  = 1000,
   localparam int PB_W      = $clog2(PAGE_BYTES),
   localparam int LEN_W     = PB_W + 1,
   localparam int DATA_W    = PAGE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_go,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              done,
   output logic              st_reject,
   output logic              st_timeout,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_io_out,
   output logic              mem_io_oe,
   input  logic              mem_io_in
);
   import sbs_pkg::*;

   localparam int DBIT_W = PB_W + 3;
   localparam int AIX_W  = $clog2(ADDR_W);

   initial begin : p_param_chk
      if (PULSE_W < 1)   $fatal(1, "PULSE_W must be at least 1");
      if (GAP_W < 1)     $fatal(1, "GAP_W must be at least 1");
      if (POLL_GAP < 1)  $fatal(1, "POLL_GAP must be at least 1");
      if (MAX_POLLS < 1) $fatal(1, "MAX_POLLS must be at least 1");
      if ((1 << PB_W) != PAGE_BYTES) $fatal(1, "PAGE_BYTES must be a power of two");
      if (ADDR_W <= PB_W || AIX_W > DBIT_W) $fatal(1, "ADDR_W does not fit the page size");
   end

   seq_st_t            sq;
   phase_t             phase;
   logic [DBIT_W-1:0]  cnt;
   logic [DBIT_W-1:0]  nb_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  data_q;
   logic               st_rej;
   logic               st_to;

   logic               req_ok;
   logic               eng_ready;
   logic               eng_fin;
   logic               eng_rbit;
   logic               eng_start;
   bus_cmd_t           cmd;
   logic               last_poll;
   logic               pause_over;
   logic               accept;
   logic               poll_low;
   logic [AIX_W-1:0]   addr_idx;

   sbs_req_check #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
      .addr (req_addr),
      .len  (req_len),
      .ok   (req_ok)
   );

   sbs_bus_cycle #(.PULSE_W(PULSE_W), .GAP_W(GAP_W)) u_bus (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (eng_start),
      .cmd    (cmd),
      .ready  (eng_ready),
      .fin    (eng_fin),
      .rbit   (eng_rbit),
      .ce_n   (mem_ce_n),
      .oe_n   (mem_oe_n),
      .we_n   (mem_we_n),
      .io_out (mem_io_out),
      .io_oe  (mem_io_oe),
      .io_in  (mem_io_in)
   );

   sbs_poll_watch #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_watch (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .poll_low   (poll_low),
      .last_poll  (last_poll),
      .pause_over (pause_over)
   );

   assign accept    = (sq == SQ_IDLE) && req_go && !done && req_ok;
   assign eng_start = (sq == SQ_ISSUE) && eng_ready;
   assign poll_low  = (sq == SQ_WAIT) && eng_fin && (phase == PH_POLL) &&
                      !eng_rbit && !last_poll;
   assign addr_idx  = AIX_W'(ADDR_W - 1) - cnt[AIX_W-1:0];

   // Bus cycle selection for the current step
   always_comb begin
      cmd = '{is_wr: 1'b0, bit_v: 1'b0};
      unique case (phase)
         PH_ADDR:    cmd = '{is_wr: 1'b1, bit_v: addr_q[addr_idx]};
         PH_DATA:    cmd = '{is_wr: 1'b1, bit_v: data_q[{cnt[DBIT_W-1:3], ~cnt[2:0]}]};
         PH_TRIG_W1: cmd = '{is_wr: 1'b1, bit_v: 1'b1};
         default:    cmd = '{is_wr: 1'b0, bit_v: 1'b0};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq     <= SQ_IDLE;
         phase  <= PH_RST;
         cnt    <= '0;
         nb_q   <= '0;
         addr_q <= '0;
         data_q <= '0;
         done   <= 1'b0;
         st_rej <= 1'b0;
         st_to  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (sq)
            SQ_IDLE: if (req_go && !done) begin
               if (req_ok) begin
                  addr_q <= req_addr;
                  data_q <= req_data;
                  nb_q   <= {PB_W'(req_len - LEN_W'(1)), 3'b111};
                  phase  <= PH_RST;
                  cnt    <= '0;
                  st_rej <= 1'b0;
                  st_to  <= 1'b0;
                  sq     <= SQ_ISSUE;
               end else begin
                  done   <= 1'b1;
                  st_rej <= 1'b1;
                  st_to  <= 1'b0;
               end
            end
            SQ_ISSUE: if (eng_ready) sq <= SQ_WAIT;
            SQ_WAIT: if (eng_fin) begin
               sq <= SQ_ISSUE;
               unique case (phase)
                  PH_RST: begin
                     phase <= PH_ADDR;
                     cnt   <= '0;
                  end
                  PH_ADDR: begin
                     if (cnt == DBIT_W'(ADDR_W - 1)) begin
                        phase <= PH_DATA;
                        cnt   <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  PH_DATA: begin
                     if (cnt == nb_q) phase <= PH_TRIG_R0;
                     else             cnt   <= cnt + 1'b1;
                  end
                  PH_TRIG_R0: phase <= PH_TRIG_W1;
                  PH_TRIG_W1: phase <= PH_TRIG_R1;
                  PH_TRIG_R1: phase <= PH_POLL;
                  PH_POLL: begin
                     if (eng_rbit) begin
                        done <= 1'b1;
                        sq   <= SQ_IDLE;
                     end else if (last_poll) begin
                        done  <= 1'b1;
                        st_to <= 1'b1;
                        sq    <= SQ_IDLE;
                     end else begin
                        sq <= SQ_PAUSE;
                     end
                  end
                  default: sq <= SQ_IDLE;
               endcase
            end
            SQ_PAUSE: if (pause_over) sq <= SQ_ISSUE;
            default: sq <= SQ_IDLE;
         endcase
      end
   end

   assign busy       = (sq != SQ_IDLE);
   assign st_reject  = st_rej;
   assign st_timeout = st_to;

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                              // R12
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R12
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_go) |=> ($stable(addr_q) && $stable(nb_q)));     // R10
   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && st_reject) |-> mem_ce_n);                            // R9

endmodule

// File: tb/bitser_prog_seq_test.sv
`timescale 1ns/1ps
module bitser_prog_seq_test;

   localparam int AW   = 16;
   localparam int PB   = 32;
   localparam int LW   = 6;
   localparam int DW   = PB * 8;
   localparam int PW   = 2;
   localparam int GW   = 1;
   localparam int PG   = 3;
   localparam int MP   = 5;
   localparam int EVMAX = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_go = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic [DW-1:0] req_data = '0;
   logic busy, done, st_reject, st_timeout;
   logic mem_ce_n, mem_oe_n, mem_we_n, mem_io_out, mem_io_oe;
   logic model_bit = 1'b0;

   int total = 0;
   int bad = 0;

   // Bus monitor state
   int   ev_n = 0;
   logic ev_wr [EVMAX];
   logic ev_bit [EVMAX];
   int   ev_w [EVMAX];
   logic in_act = 1'b0;
   logic cur_wr = 1'b0;
   logic cur_bit = 1'b0;
   int   cur_w = 0;
   int   gap_run = 10;
   int   gap_bad = 0;
   int   both_bad = 0;
   int   drive_bad = 0;
   int   poll_base = 1 << 30;
   int   busy_left = 0;
   int   done_seen = 0;

   always #2 clk = ~clk;

   bitser_prog_seq #(
      .ADDR_W(AW), .PAGE_BYTES(PB), .PULSE_W(PW), .GAP_W(GW),
      .POLL_GAP(PG), .MAX_POLLS(MP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_addr(req_addr),
      .req_len(req_len), .req_data(req_data), .busy(busy), .done(done),
      .st_reject(st_reject), .st_timeout(st_timeout),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_io_out(mem_io_out), .mem_io_oe(mem_io_oe), .mem_io_in(model_bit)
   );

   // Memory model and bus monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) done_seen++;
         if (!mem_oe_n && !mem_we_n) both_bad++;
         if (mem_io_oe && mem_we_n) drive_bad++;
         if (!mem_ce_n) begin
            if (!in_act) begin
               in_act = 1'b1;
               cur_w = 0;
               cur_wr = !mem_we_n;
               cur_bit = 1'b0;
               if (gap_run < 1) gap_bad++;
               if (mem_we_n) begin
                  if (ev_n >= poll_base) begin
                     if (busy_left > 0) begin
                        model_bit = 1'b0;
                        busy_left--;
                     end else begin
                        model_bit = 1'b1;
                     end
                  end else begin
                     model_bit = 1'b0;
                  end
               end
            end
            cur_w++;
            if (!mem_we_n) cur_bit = mem_io_out;
         end else begin
            if (in_act) begin
               if (ev_n < EVMAX) begin
                  ev_wr[ev_n] = cur_wr;
                  ev_bit[ev_n] = cur_bit;
                  ev_w[ev_n] = cur_w;
               end
               ev_n++;
               in_act = 1'b0;
               gap_run = 0;
            end
            gap_run++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] dbyte(input int seed, input int i);
      return 8'((i * 37) + (seed * 11) + 5);
   endfunction

   // One request; intrude_at > 0 pulses a second go while busy
   task automatic run_txn(input int addr, input int len, input int nbusy,
                          input int seed, input int intrude_at);
      int wait_cnt;
      int exp_polls;
      int exp_ev;
      int mism;
      int first;
      logic s_rej, s_to;
      @(negedge clk);
      ev_n = 0;
      done_seen = 0;
      poll_base = 1 + 16 + 8 * len + 3;
      busy_left = nbusy;
      req_addr = AW'(addr);
      req_len = LW'(len);
      for (int i = 0; i < PB; i++) req_data[i*8 +: 8] = dbyte(seed, i);
      req_go = 1'b1;
      @(negedge clk);
      req_go = 1'b0;
      wait_cnt = 0;
      while (!done && wait_cnt < 20000) begin
         @(negedge clk);
         wait_cnt++;
         if (intrude_at > 0 && wait_cnt == intrude_at) begin
            req_addr = ~AW'(addr);
            req_len = LW'(1);
            req_go = 1'b1;
         end else begin
            req_go = 1'b0;
         end
      end
      if (!done) begin
         check(1'b0, "R7", "watchdog waiting for done", wait_cnt, 0);
         return;
      end
      s_rej = st_reject;
      s_to = st_timeout;
      check(!busy, "R12", "busy in done cycle", busy, 0);
      @(negedge clk);
      check(!done, "R12", "done width", done, 0);

      exp_polls = (nbusy < MP) ? nbusy + 1 : MP;
      exp_ev = poll_base + exp_polls;
      check(ev_n == exp_ev, "R4", "bus cycle count", ev_n, exp_ev);
      if (ev_n != exp_ev) return;

      // R2: reset read then address MSB first
      mism = 0; first = -1;
      if (ev_wr[0]) begin mism++; first = 0; end
      for (int i = 0; i < 16; i++)
         if (!ev_wr[1+i] || ev_bit[1+i] != addr[15-i]) begin
            mism++; if (first < 0) first = 1 + i;
         end
      check(mism == 0, "R2", "address stream mismatch at cycle", first, -1);

      // R3: data bytes in order, bit 7 first
      mism = 0; first = -1;
      for (int b = 0; b < len; b++)
         for (int k = 0; k < 8; k++) begin
            int e;
            logic [7:0] v;
            e = 17 + b * 8 + k;
            v = dbyte(seed, b);
            if (!ev_wr[e] || ev_bit[e] != v[7-k]) begin
               mism++; if (first < 0) first = e;
            end
         end
      check(mism == 0, "R3", "data stream mismatch at cycle", first, -1);

      // R4: read, write 1, read
      check(!ev_wr[poll_base-3] && ev_wr[poll_base-2] && ev_bit[poll_base-2] &&
            !ev_wr[poll_base-1], "R4", "trigger pattern",
            {ev_wr[poll_base-3], ev_wr[poll_base-2], ev_bit[poll_base-2],
             ev_wr[poll_base-1]}, 4'b0110);

      // R11: every strobe is PW clocks wide
      mism = 0;
      for (int i = 0; i < ev_n; i++) if (ev_w[i] != PW) mism++;
      check(mism == 0, "R11", "strobe widths off", mism, 0);

      check(!s_rej, "R9", "st_reject on valid request", s_rej, 0);
      if (nbusy < MP)
         check(!s_to, "R7", "st_timeout after line went high", s_to, 0);
      else
         check(s_to, "R8", "st_timeout after poll budget", s_to, 1);

      if (intrude_at > 0) begin
         repeat (40) @(negedge clk);
         check(done_seen == 1 && ev_n == exp_ev && !busy, "R10",
               "extra activity after ignored go", done_seen * 1000 + ev_n,
               1000 + exp_ev);
      end
   endtask

   task automatic reject_txn(input int addr, input int len);
      int wait_cnt;
      @(negedge clk);
      ev_n = 0;
      req_addr = AW'(addr);
      req_len = LW'(len);
      req_go = 1'b1;
      @(negedge clk);
      req_go = 1'b0;
      wait_cnt = 0;
      while (!done && wait_cnt < 10) begin
         @(negedge clk);
         wait_cnt++;
      end
      check(done && st_reject && !st_timeout, "R9", "reject status",
            {done, st_reject, st_timeout}, 3'b110);
      repeat (20) @(negedge clk);
      check(ev_n == 0 && !busy, "R9", "bus cycles after reject", ev_n, 0);
   endtask

   initial begin : p_watchdog
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      // R1: idle state under reset and just after
      check(mem_ce_n && mem_oe_n && mem_we_n && !mem_io_oe && !busy && !done,
            "R1", "reset outputs",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_io_oe, busy, done}, 6'b111000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(mem_ce_n && mem_oe_n && mem_we_n && !mem_io_oe && !busy && !done,
            "R1", "outputs after reset release",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_io_oe, busy, done}, 6'b111000);

      // Sweep every length, page-aligned and flush to page end (R2 R3 R7)
      for (int L = 1; L <= PB; L++) begin
         int hi;
         hi = ((L * 1187) << 5) & 16'hFFE0;
         run_txn(hi, L, L % 4, L, 0);
         run_txn(hi | (PB - L), L, (L + 1) % 4, L + 100, 0);
      end
      // Poll limit boundaries: last allowed poll, then one too many (R7 R8)
      run_txn(16'h1200, 3, MP - 1, 7, 0);
      run_txn(16'h1240, 4, MP, 8, 0);
      run_txn(16'h3300, 2, MP + 5, 9, 0);
      // Rejected requests (R9)
      reject_txn(16'h0000, 0);
      reject_txn(16'h0040, 33);
      reject_txn(16'h005F, 2);
      reject_txn(16'h0081, 32);
      reject_txn(16'h0100, 63);
      // Go while busy is ignored (R10)
      run_txn(16'hA5C0, 5, 2, 21, 30);

      // R5 and R6: bus rule violations seen by the monitor
      check(gap_bad == 0 && both_bad == 0, "R5", "bus cycle rule violations",
            gap_bad + both_bad, 0);
      check(drive_bad == 0, "R6", "data line driven outside write", drive_bad, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule